// File: doc/BRIEF.md
# Multiplierless Constant-Coefficient FIR Filter

A seven-tap FIR filter whose coefficients are fixed when the design is elaborated. It contains no multipliers. Each coefficient is recoded into non-adjacent signed-digit (canonic) form and then cut down to its three most significant nonzero digits. Each digit that remains becomes one shifted copy of a delayed input sample. That copy is inverted when the digit is negative, and the +1 terms those inversions need are folded into one constant row.

All partial-product rows from all taps go into one carry-save tree. Its stages are built from 6:3 counters while six or more rows remain, and from 3:2 counters after that, until two rows are left. A single carry-propagate adder adds those two rows. The result is registered and presented at full precision.

Samples arrive as a stream, qualified by a valid flag. Each accepted sample produces one result on the next clock edge. Cycles without a valid sample leave the filter state unchanged.

Top module: `csd_fir`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_y` is 0, and the sample history is cleared to zero.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock cycle.
- R3: After an edge at which `in_valid` was high, `out_y` equals the sum over k = 0..6 of h_k * x(n-k). Here x(n) is the sample presented at that edge, and x(n-k) is the sample accepted k acceptances earlier, or zero if none has been accepted since reset. h_k is the truncated value of the signed 16-bit coefficient held in bits [16k+15:16k] of `COEF_VEC`.
- R4: h_k is the sum of the three most significant nonzero digits of the coefficient's non-adjacent signed-digit form. With the default coefficients, 14746 becomes 14848, -655 becomes -656, and 123 stays 123.
- R5: An edge with `in_valid` low consumes no sample. `out_y` holds its value, and the history is unchanged for later results.
- R6: `out_y` is a 36-bit two's complement value that never wraps, including for runs of 32767 or -32768 on every tap.
- R7: Every stage of the reduction tree preserves the sum of its rows modulo 2^36. A stage uses 6:3 counters while it has at least six input rows and 3:2 counters below that, and the final two rows go to one adder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample qualifier |
| in_sample | input | 16 | Signed Q1.15 input sample |
| out_valid | output | 1 | Result qualifier, one cycle after `in_valid` |
| out_y | output | 36 | Signed full-precision filter output |

## Verification
The clocked properties assume that `in_valid` and `in_sample` are known, stable values at every rising edge once reset is released. The bench meets this by changing its inputs only on falling edges. The row-sum property inside each tree stage assumes only that its input rows are defined. The bench keeps that true by releasing reset before it applies any sample.

The stimulus includes signed impulses on every bit weight and long runs at both extreme sample values. It also includes a pseudo-random stream in which about one cycle in four carries no valid sample, so the hold behaviour and the history's tap ordering are both exercised.

// File: rtl/csd_fir_pkg.sv
`timescale 1ns/1ps
package csd_fir_pkg;

  localparam int CSD_SPAN = 40;

  // Nonzero digit of rank 'rank' counted from the most significant end of the
  // non-adjacent signed-digit form of 'coef'. Returns its position when
  // want_pos is set, otherwise its sign (+1/-1); 0 when no such digit exists.
  function automatic int csd_term(input int coef, input int rank, input bit want_pos);
    int v;
    int d;
    int total;
    int seen;
    int res;
    v = coef;
    total = 0;
    for (int i = 0; i < CSD_SPAN; i++) begin
      if ((v & 1) != 0) begin
        d = ((v & 3) == 1) ? 1 : -1;
        total = total + 1;
        v = v - d;
      end
      v = v >>> 1;
    end
    v = coef;
    seen = 0;
    res = 0;
    for (int i = 0; i < CSD_SPAN; i++) begin
      if ((v & 1) != 0) begin
        d = ((v & 3) == 1) ? 1 : -1;
        if (seen == total - 1 - rank) res = want_pos ? i : d;
        seen = seen + 1;
        v = v - d;
      end
      v = v >>> 1;
    end
    return res;
  endfunction

  // Row count after one reduction stage.
  function automatic int tree_next(input int n);
    if (n >= 6) return 3 * (n / 6) + (n % 6);
    if (n > 2) return 2 * (n / 3) + (n % 3);
    return n;
  endfunction

  function automatic int tree_depth(input int n0);
    int n;
    int k;
    n = n0;
    k = 0;
    for (int i = 0; i < 64; i++) begin
      if (n > 2) begin
        n = tree_next(n);
        k = k + 1;
      end
    end
    return k;
  endfunction

  // Rows entering stage s.
  function automatic int tree_rows(input int n0, input int s);
    int n;
    n = n0;
    for (int i = 0; i < 64; i++) begin
      if (i < s) n = tree_next(n);
    end
    return n;
  endfunction

endpackage

// File: rtl/csd_fir_cnt63.sv
`timescale 1ns/1ps
module csd_fir_cnt63 (
  input  logic [5:0] bits_i,
  output logic [2:0] cnt_o
);

  assign cnt_o = 3'(bits_i[0]) + 3'(bits_i[1]) + 3'(bits_i[2])
               + 3'(bits_i[3]) + 3'(bits_i[4]) + 3'(bits_i[5]);

endmodule

// File: rtl/csd_fir_fa.sv
`timescale 1ns/1ps
module csd_fir_fa (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic co_o
);

  assign s_o  = a_i ^ b_i ^ c_i;
  assign co_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);

endmodule

// File: rtl/csd_fir_taps.sv
`timescale 1ns/1ps
module csd_fir_taps #(
  parameter int DATA_W = 16,
  parameter int TAPS   = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shift_en,
  input  logic [DATA_W-1:0]        din,
  output logic [TAPS*DATA_W-1:0]   taps_o
);

  localparam int DEPTH = TAPS - 1;

  logic [DEPTH*DATA_W-1:0] line_q;
  logic [DEPTH*DATA_W-1:0] line_d;

  always_comb begin
    line_d = line_q;
    if (shift_en) begin
      for (int k = 0; k < DEPTH; k++) begin
        if (k == 0) line_d[k*DATA_W +: DATA_W] = din;
        else        line_d[k*DATA_W +: DATA_W] = line_q[(k-1)*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_d;
  end

  // tap 0 is the sample being presented, tap k the k-th previous one
  assign taps_o = {line_q, din};

  // R5: no sample is consumed when the shift enable is low
  p_taps_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(line_q));

  // R3: the newest delayed tap holds the sample accepted at the previous edge
  p_taps_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> line_q[DATA_W-1:0] == $past(din));

endmodule

// File: rtl/csd_fir_pp_gen.sv
`timescale 1ns/1ps
module csd_fir_pp_gen
  import csd_fir_pkg::*;
#(
  parameter int                      DATA_W     = 16,
  parameter int                      COEF_W     = 16,
  parameter int                      TAPS       = 7,
  parameter int                      MAX_DIGITS = 3,
  parameter logic [TAPS*COEF_W-1:0]  COEF_VEC   = '0,
  parameter int                      ACC_W      = 36,
  localparam int                     ROWS       = TAPS * MAX_DIGITS + 1
) (
  input  logic [TAPS*DATA_W-1:0] taps_i,
  output wire  [ROWS*ACC_W-1:0]  rows_o
);

  function automatic int coef_at(input int t);
    return int'($signed(COEF_VEC[t*COEF_W +: COEF_W]));
  endfunction

  // one +1 per negative digit completes the two's complement negations
  function automatic int neg_total();
    int n;
    n = 0;
    for (int t = 0; t < TAPS; t++) begin
      for (int d = 0; d < MAX_DIGITS; d++) begin
        if (csd_term(coef_at(t), d, 1'b0) < 0) n = n + 1;
      end
    end
    return n;
  endfunction

  localparam int               NEG_CNT = neg_total();
  localparam logic [ACC_W-1:0] CORR    = ACC_W'(NEG_CNT);

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    wire [ACC_W-1:0] ext = {{(ACC_W-DATA_W){taps_i[t*DATA_W+DATA_W-1]}},
                            taps_i[t*DATA_W +: DATA_W]};
    for (genvar d = 0; d < MAX_DIGITS; d++) begin : g_dig
      localparam int SGN = csd_term(coef_at(t), d, 1'b0);
      localparam int POS = csd_term(coef_at(t), d, 1'b1);
      if (SGN > 0) begin : g_pos
        assign rows_o[(t*MAX_DIGITS+d)*ACC_W +: ACC_W] = ext << POS;
      end else if (SGN < 0) begin : g_neg
        assign rows_o[(t*MAX_DIGITS+d)*ACC_W +: ACC_W] = ~(ext << POS);
      end else begin : g_zero
        assign rows_o[(t*MAX_DIGITS+d)*ACC_W +: ACC_W] = '0;
      end
    end
  end

  assign rows_o[(ROWS-1)*ACC_W +: ACC_W] = CORR;

endmodule

// File: rtl/csd_fir_csa_stage.sv
`timescale 1ns/1ps
module csd_fir_csa_stage #(
  parameter int W     = 36,
  parameter int N_IN  = 6,
  parameter int N_OUT = 3
) (
  input  logic [N_IN*W-1:0]  rows_i,
  output wire  [N_OUT*W-1:0] rows_o
);

  localparam bit WIDE = (N_IN >= 6);
  localparam int FAN  = WIDE ? 6 : 3;
  localparam int OUTS = WIDE ? 3 : 2;
  localparam int GRP  = N_IN / FAN;
  localparam int REST = N_IN - GRP * FAN;

  for (genvar g = 0; g < GRP; g++) begin : g_grp
    if (WIDE) begin : g_c63
      wire [W-1:0] c0;
      wire [W-1:0] c1;
      wire [W-1:0] c2;
      for (genvar i = 0; i < W; i++) begin : g_col
        csd_fir_cnt63 u_cnt (
          .bits_i({rows_i[(g*6+5)*W+i], rows_i[(g*6+4)*W+i], rows_i[(g*6+3)*W+i],
                   rows_i[(g*6+2)*W+i], rows_i[(g*6+1)*W+i], rows_i[(g*6)*W+i]}),
          .cnt_o ({c2[i], c1[i], c0[i]})
        );
      end
      assign rows_o[(g*3)*W +: W]   = c0;
      assign rows_o[(g*3+1)*W +: W] = c1 << 1;
      assign rows_o[(g*3+2)*W +: W] = c2 << 2;
    end else begin : g_c32
      wire [W-1:0] sm;
      wire [W-1:0] cy;
      for (genvar i = 0; i < W; i++) begin : g_col
        csd_fir_fa u_fa (
          .a_i (rows_i[(g*3)*W+i]),
          .b_i (rows_i[(g*3+1)*W+i]),
          .c_i (rows_i[(g*3+2)*W+i]),
          .s_o (sm[i]),
          .co_o(cy[i])
        );
      end
      assign rows_o[(g*2)*W +: W]   = sm;
      assign rows_o[(g*2+1)*W +: W] = cy << 1;
    end
  end

  for (genvar r = 0; r < REST; r++) begin : g_pass
    assign rows_o[(GRP*OUTS+r)*W +: W] = rows_i[(GRP*FAN+r)*W +: W];
  end

  logic [W-1:0] sum_in;
  logic [W-1:0] sum_out;

  always_comb begin
    sum_in  = '0;
    sum_out = '0;
    for (int r = 0; r < N_IN; r++)  sum_in  = sum_in  + rows_i[r*W +: W];
    for (int r = 0; r < N_OUT; r++) sum_out = sum_out + rows_o[r*W +: W];
    // R7: the stage neither gains nor loses weight
    p_sum_keep_r7: assert (sum_in == sum_out)
      else $error("reduction stage changed the row sum");
  end

endmodule

// File: rtl/csd_fir.sv
`timescale 1ns/1ps
module csd_fir
  import csd_fir_pkg::*;
#(
  parameter int                     DATA_W     = 16,
  parameter int                     COEF_W     = 16,
  parameter int                     TAPS       = 7,
  parameter int                     MAX_DIGITS = 3,
  parameter logic [TAPS*COEF_W-1:0] COEF_VEC   = {16'h007B, 16'hF447, 16'h1B58, 16'h399A,
                                                  16'h23D7, 16'h07AE, 16'hFD71},
  parameter int                     ACC_W      = DATA_W + COEF_W + $clog2(TAPS) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_sample,
  output logic              out_valid,
  output logic [ACC_W-1:0]  out_y
);

  localparam int ROWS0 = TAPS * MAX_DIGITS + 1;
  localparam int NSTG  = tree_depth(ROWS0);

  logic [TAPS*DATA_W-1:0] taps;
  wire  [ROWS0*ACC_W-1:0] pp_rows;
  logic [ACC_W-1:0]       sum_w;
  logic [ACC_W-1:0]       y_d;
  logic [ACC_W-1:0]       y_q;
  logic                   vld_q;

  csd_fir_taps #(
    .DATA_W(DATA_W),
    .TAPS  (TAPS)
  ) u_taps (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(in_valid),
    .din     (in_sample),
    .taps_o  (taps)
  );

  csd_fir_pp_gen #(
    .DATA_W    (DATA_W),
    .COEF_W    (COEF_W),
    .TAPS      (TAPS),
    .MAX_DIGITS(MAX_DIGITS),
    .COEF_VEC  (COEF_VEC),
    .ACC_W     (ACC_W)
  ) u_pp (
    .taps_i(taps),
    .rows_o(pp_rows)
  );

  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    localparam int NI = tree_rows(ROWS0, s);
    localparam int NO = tree_rows(ROWS0, s + 1);
    wire [NO*ACC_W-1:0] rows;
    if (s == 0) begin : g_first
      csd_fir_csa_stage #(.W(ACC_W), .N_IN(NI), .N_OUT(NO)) u_stg (
        .rows_i(pp_rows),
        .rows_o(rows)
      );
    end else begin : g_next
      csd_fir_csa_stage #(.W(ACC_W), .N_IN(NI), .N_OUT(NO)) u_stg (
        .rows_i(g_stage[s-1].rows),
        .rows_o(rows)
      );
    end
  end

  // final carry-propagate adder on the two surviving rows
  if (NSTG == 0) begin : g_cpa_direct
    assign sum_w = pp_rows[0 +: ACC_W] + pp_rows[ACC_W +: ACC_W];
  end else begin : g_cpa_tree
    assign sum_w = g_stage[NSTG-1].rows[0 +: ACC_W] + g_stage[NSTG-1].rows[ACC_W +: ACC_W];
  end

  always_comb begin
    y_d = y_q;
    if (in_valid) y_d = sum_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q   <= '0;
      vld_q <= 1'b0;
    end else begin
      y_q   <= y_d;
      vld_q <= in_valid;
    end
  end

  assign out_y     = y_q;
  assign out_valid = vld_q;

  p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_y));

endmodule

// File: tb/sim_csd_fir.sv
`timescale 1ns/1ps
module sim_csd_fir;

  localparam int DW   = 16;
  localparam int TAPS = 7;
  localparam int AW   = 36;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [DW-1:0] in_sample;
  wire           out_valid;
  wire  [AW-1:0] out_y;

  always #10 clk = ~clk;

  csd_fir u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sample(in_sample),
    .out_valid(out_valid),
    .out_y    (out_y)
  );

  int     n_chk  = 0;
  int     n_fail = 0;
  longint tc   [TAPS];
  longint hist [TAPS];
  longint exp_y;
  logic   exp_v;
  logic [31:0] lf = 32'h1234_5678;
  longint raw [TAPS] = '{-655, 1966, 9175, 14746, 7000, -3001, 123};

  // truncated coefficient via the sparse-form bit identity, top three digits
  function automatic longint trunc_value(input longint c);
    longint m, xh, x3, cc, np, nm, acc;
    int kept;
    m  = (c < 0) ? -c : c;
    xh = m >> 1;
    x3 = m + xh;
    cc = xh ^ x3;
    np = x3 & cc;
    nm = xh & cc;
    acc = 0;
    kept = 0;
    for (int i = 40; i >= 0; i--) begin
      if (kept < 3 && np[i]) begin acc = acc + (longint'(1) << i); kept++; end
      else if (kept < 3 && nm[i]) begin acc = acc - (longint'(1) << i); kept++; end
    end
    return (c < 0) ? -acc : acc;
  endfunction

  task automatic check(input string tag, input bit ok, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic longint y_now();
    return longint'($signed(out_y));
  endfunction

  task automatic step(input bit v, input longint s, input string tag);
    in_valid  = v;
    in_sample = s[DW-1:0];
    if (v) begin
      for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = longint'($signed(s[DW-1:0]));
      exp_y = 0;
      for (int k = 0; k < TAPS; k++) exp_y = exp_y + tc[k] * hist[k];
    end
    exp_v = v;
    @(negedge clk);
    check("R2", out_valid === exp_v, longint'(out_valid), longint'(exp_v));
    check(tag, y_now() == exp_y, y_now(), exp_y);
  endtask

  initial begin
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_sample = '0;
    exp_y     = 0;
    exp_v     = 1'b0;
    for (int k = 0; k < TAPS; k++) begin
      tc[k]   = trunc_value(raw[k]);
      hist[k] = 0;
    end

    repeat (3) @(negedge clk);
    check("R1", out_valid === 1'b0, longint'(out_valid), 0);
    check("R1", out_y === '0, y_now(), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", out_valid === 1'b0, longint'(out_valid), 0);

    // unit impulse: response reads back each truncated coefficient (R4)
    for (int k = 0; k < TAPS + 1; k++) begin
      step(1'b1, (k == 0) ? 1 : 0, "R3");
      if (k == 0) check("R4", y_now() == -656, y_now(), -656);
      if (k == 3) check("R4", y_now() == 14848, y_now(), 14848);
      if (k == 6) check("R4", y_now() == 123, y_now(), 123);
    end

    // signed impulses on every bit weight
    for (int b = 0; b < DW; b++) begin
      for (int sg = 0; sg < 2; sg++) begin
        longint amp;
        amp = (b == DW - 1) ? ((sg == 0) ? 32767 : -32768)
                            : ((sg == 0) ? (longint'(1) << b) : -(longint'(1) << b));
        step(1'b1, amp, "R3");
        for (int k = 0; k < TAPS; k++) step(1'b1, 0, "R3");
      end
    end

    // extremes: full precision, no wrap
    for (int k = 0; k < 9; k++) step(1'b1, 32767, "R6");
    for (int k = 0; k < 9; k++) step(1'b1, -32768, "R6");
    for (int k = 0; k < 16; k++) step(1'b1, (k % 2 == 0) ? 32767 : -32768, "R6");
    for (int k = 0; k < 16; k++) step(1'b1, (k % 2 == 0) ? -32768 : 32767, "R6");

    // pseudo-random stream with idle cycles
    for (int k = 0; k < 1500; k++) begin
      bit v;
      lf = lf ^ (lf << 13);
      lf = lf ^ (lf >> 17);
      lf = lf ^ (lf << 5);
      v = (lf[9:8] != 2'b00);
      step(v, longint'($signed(lf[31:16])), v ? "R3" : "R5");
    end
    for (int k = 0; k < 5; k++) step(1'b0, 12345, "R5");
    step(1'b1, -1, "R3");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule